// File: doc/BRIEF.md
# Memory Protection Configuration Register File

This block keeps the state that a physical memory protection unit needs: one 8-bit configuration byte and one address register for each of sixteen regions, and a small machine security register. Software reaches it through a register-style access port with a write strobe, a read strobe, a register class select, an index and a 32-bit data word. All configuration bytes, addresses and security flags are driven out continuously to the region decoder and the permission checker, which sit outside this block.

Several configuration bytes share one access word, one byte per lane. Whether a write lands is decided per byte or per register by the lock rules. A region whose lock flag is set refuses changes, and a locked neighbour that uses top-of-range matching also protects the address register below it. A bypass flag overrides the configuration lock, and the machine lockdown mode replaces the lock test with a test on the value being written. Two security flags cannot be cleared once set, and the bypass flag cannot be raised while any region is locked. A write that is refused is dropped without any indication.

Top module: `pcfg_regfile`

## Requirements
- R1: A configuration byte is stored and output exactly as written. Its fields are: read permission at bit 0, write permission at bit 1, execute permission at bit 2, match mode at bits 4:3 (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), and lock flag at bit 7. Region i's byte appears on `region_cfg_o[8i+7:8i]`.
- R2: Configuration word k (select 0) carries region 4k+j in data bits 8j+7:8j for j = 0..3, on both writes and reads.
- R3: With lockdown and bypass both clear, a configuration byte write to a region whose current lock flag is 1 is ignored. The other lanes of the same word are still judged on their own.
- R4: A write to region i's address register (select 1, index i) is ignored while region i's lock flag is 1.
- R5: A write to region i's address register is also ignored while region i+1 has lock flag 1 and match mode 1. Region 15 has no such neighbour.
- R6: While the bypass flag is 1, every configuration byte write is accepted, whatever the lock flags and the lockdown flag hold.
- R7: While lockdown is 1 and bypass is 0, a configuration byte write is accepted exactly when the new byte has bit 7 = 1 and bit 2 = 0, or has bit 7 = 0 and bits 2:0 differ from 3'b110. The current lock flag plays no part.
- R8: The security register (select 2, index ignored) holds lockdown at bit 0, whitelist policy at bit 1 and bypass at bit 2, and reads back in those bits with zeros above. Once set, lockdown and whitelist stay set until reset.
- R9: While bypass is 0 and any region's lock flag is 1, a security write leaves bypass at 0. Bypass itself is not sticky.
- R10: Configuration indices 4 and above, address indices 16 and above, and select 3 are out of range. Writes to them change nothing, and reads of them return zero.
- R11: Reset clears every configuration byte, address and security flag. An accepted write shows on the outputs after the next rising clock edge. Read data is combinational from the current state and is zero when the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| csr_we | input | 1 | Write strobe |
| csr_re | input | 1 | Read strobe |
| csr_sel | input | 2 | Register class: 0 configuration word, 1 address, 2 security, 3 none |
| csr_idx | input | 5 | Register index within the class |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, same cycle |
| region_cfg_o | output | 128 | All configuration bytes, region i at bits 8i+7:8i |
| region_addr_o | output | 512 | All address registers, region i at bits 32i+31:32i |
| sec_lockdown_o | output | 1 | Machine lockdown flag |
| sec_whitelist_o | output | 1 | Whitelist policy flag |
| sec_bypass_o | output | 1 | Rule lock bypass flag |

## Verification
A read and a write can target the same register in the same cycle. Every write in the bench is issued with the read strobe also raised on the same index, so this case is exercised throughout. The read must return the value held before the edge, and the outputs must not move until that edge has passed. The bench drives both strobes together and samples the read data before the edge and the outputs after it. It judges both against a reference that applies the lock, lockdown, bypass and stickiness rules to the values held before the write. The sweeps run all 256 byte values against the lock rule and against the lockdown rule, and cover the neighbour top-of-range case.

// File: rtl/pcfg_pkg.sv
`timescale 1ns/1ps
package pcfg_pkg;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_SEC  = 2'd2,
    SEL_NONE = 2'd3
  } csr_sel_e;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_TOR   = 2'd1,
    MATCH_NA4   = 2'd2,
    MATCH_NAPOT = 2'd3
  } match_e;

  localparam int unsigned CFG_W      = 8;
  localparam int unsigned BIT_W      = 1;
  localparam int unsigned BIT_X      = 2;
  localparam int unsigned MODE_LO    = 3;
  localparam int unsigned BIT_L      = 7;

  localparam int unsigned SEC_W      = 3;
  localparam int unsigned SEC_LD     = 0;
  localparam int unsigned SEC_WL     = 1;
  localparam int unsigned SEC_BYP    = 2;

endpackage

// File: rtl/pcfg_region_slot.sv
`timescale 1ns/1ps
module pcfg_region_slot
  import pcfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter bit          HAS_NEXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic [CFG_W-1:0]  next_cfg,
  input  logic              lockdown,
  input  logic              bypass,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [ADDR_W-1:0] addr_q
);

  logic              ld_value_ok;
  logic              cfg_accept;
  logic              nbr_guard;
  logic              addr_accept;
  logic              cfg_en;
  logic              addr_en;
  logic [CFG_W-1:0]  cfg_d;
  logic [ADDR_W-1:0] addr_d;

  // lockdown mode judges the incoming value instead of the current lock flag
  always_comb begin
    if (cfg_wdata[BIT_L]) begin
      ld_value_ok = !cfg_wdata[BIT_X];
    end else begin
      ld_value_ok = (cfg_wdata[BIT_X:0] != 3'b110);
    end
  end

  always_comb begin
    if (bypass) begin
      cfg_accept = 1'b1;
    end else if (lockdown) begin
      cfg_accept = ld_value_ok;
    end else begin
      cfg_accept = !cfg_q[BIT_L];
    end
  end

  generate
    if (HAS_NEXT) begin : g_nbr
      assign nbr_guard = next_cfg[BIT_L] &&
                         (match_e'(next_cfg[MODE_LO +: 2]) == MATCH_TOR);
    end else begin : g_top
      assign nbr_guard = 1'b0;
    end
  endgenerate

  assign addr_accept = !cfg_q[BIT_L] && !nbr_guard;
  assign cfg_en      = cfg_we && cfg_accept;
  assign addr_en     = addr_we && addr_accept;

  always_comb begin
    cfg_d  = cfg_q;
    addr_d = addr_q;
    if (cfg_en)  cfg_d  = cfg_wdata;
    if (addr_en) addr_d = addr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  // R3: plain lock refuses configuration changes
  a_r3_locked_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !bypass && !lockdown && cfg_q[BIT_L]) |=> $stable(cfg_q));

  // R4: own lock protects the address register
  a_r4_locked_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_we && cfg_q[BIT_L]) |=> $stable(addr_q));

  // R5: locked top-of-range neighbour protects the address register
  a_r5_nbr_tor_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_NEXT && addr_we && next_cfg[BIT_L] && next_cfg[4:3] == 2'b01)
      |=> $stable(addr_q));

  // R6: bypass takes every configuration write
  a_r6_bypass_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && bypass) |=> (cfg_q == $past(cfg_wdata)));

  // R7: lockdown rejects write+execute shared values and locked executables
  a_r7_lockdown_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && lockdown && !bypass &&
     ((cfg_wdata[7] && cfg_wdata[2]) || (!cfg_wdata[7] && cfg_wdata[2:0] == 3'b110)))
      |=> $stable(cfg_q));

endmodule

// File: rtl/pcfg_sec_reg.sv
`timescale 1ns/1ps
module pcfg_sec_reg
  import pcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEC_W-1:0] wdata,
  input  logic             any_locked,
  output logic [SEC_W-1:0] sec_q
);

  logic [SEC_W-1:0] sec_d;

  always_comb begin
    sec_d = wdata;
    if (!sec_q[SEC_BYP] && any_locked) begin
      sec_d[SEC_BYP] = 1'b0;
    end
    sec_d[SEC_LD] = wdata[SEC_LD] | sec_q[SEC_LD];
    sec_d[SEC_WL] = wdata[SEC_WL] | sec_q[SEC_WL];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
    end else if (we) begin
      sec_q <= sec_d;
    end
  end

  // R8: sticky mode flags
  a_r8_lockdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q[0] |=> sec_q[0]);
  a_r8_whitelist_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q[1] |=> sec_q[1]);

  // R9: bypass cannot rise while a region is locked
  a_r9_bypass_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_q[2] && any_locked) |=> !sec_q[2]);

endmodule

// File: rtl/pcfg_read_mux.sv
`timescale 1ns/1ps
module pcfg_read_mux
  import pcfg_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 16,
  parameter int unsigned XLEN        = 32,
  parameter int unsigned IDX_W       = 5
) (
  input  logic                        re,
  input  logic [1:0]                  sel,
  input  logic [IDX_W-1:0]            idx,
  input  logic [NUM_REGIONS*CFG_W-1:0] cfg_flat,
  input  logic [NUM_REGIONS*XLEN-1:0]  addr_flat,
  input  logic [SEC_W-1:0]            sec,
  output logic [XLEN-1:0]             rdata
);

  localparam int unsigned LANES     = XLEN / CFG_W;
  localparam int unsigned CFG_WORDS = (NUM_REGIONS + LANES - 1) / LANES;

  always_comb begin
    rdata = '0;
    if (re) begin
      unique case (csr_sel_e'(sel))
        SEL_CFG: begin
          for (int k = 0; k < CFG_WORDS; k++) begin
            if (idx == IDX_W'(k)) begin
              for (int j = 0; j < LANES; j++) begin
                if (k * LANES + j < NUM_REGIONS) begin
                  rdata[j*CFG_W +: CFG_W] = cfg_flat[(k*LANES+j)*CFG_W +: CFG_W];
                end
              end
            end
          end
        end
        SEL_ADDR: begin
          for (int i = 0; i < NUM_REGIONS; i++) begin
            if (idx == IDX_W'(i)) begin
              rdata = addr_flat[i*XLEN +: XLEN];
            end
          end
        end
        SEL_SEC:  rdata[SEC_W-1:0] = sec;
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/pcfg_regfile.sv
`timescale 1ns/1ps
module pcfg_regfile
  import pcfg_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 16,
  parameter int unsigned XLEN        = 32,
  parameter int unsigned IDX_W       = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          csr_we,
  input  logic                          csr_re,
  input  logic [1:0]                    csr_sel,
  input  logic [IDX_W-1:0]              csr_idx,
  input  logic [XLEN-1:0]               csr_wdata,
  output logic [XLEN-1:0]               csr_rdata,
  output logic [NUM_REGIONS*CFG_W-1:0]  region_cfg_o,
  output logic [NUM_REGIONS*XLEN-1:0]   region_addr_o,
  output logic                          sec_lockdown_o,
  output logic                          sec_whitelist_o,
  output logic                          sec_bypass_o
);

  localparam int unsigned LANES     = XLEN / CFG_W;
  localparam int unsigned CFG_WORDS = (NUM_REGIONS + LANES - 1) / LANES;
  localparam logic [IDX_W:0] CFG_LIMIT  = (IDX_W+1)'(CFG_WORDS);
  localparam logic [IDX_W:0] ADDR_LIMIT = (IDX_W+1)'(NUM_REGIONS);

  logic                   cfg_hit;
  logic                   addr_hit;
  logic                   sec_we;
  logic                   any_locked;
  logic [SEC_W-1:0]       sec_q;
  logic [CFG_W-1:0]       cfg_arr [NUM_REGIONS+1];

  assign cfg_hit  = csr_we && (csr_sel_e'(csr_sel) == SEL_CFG)  &&
                    ({1'b0, csr_idx} < CFG_LIMIT);
  assign addr_hit = csr_we && (csr_sel_e'(csr_sel) == SEL_ADDR) &&
                    ({1'b0, csr_idx} < ADDR_LIMIT);
  assign sec_we   = csr_we && (csr_sel_e'(csr_sel) == SEL_SEC);

  assign cfg_arr[NUM_REGIONS] = '0;

  generate
    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
      localparam int unsigned WORD = i / LANES;
      localparam int unsigned LANE = i % LANES;
      logic slot_cfg_we;
      logic slot_addr_we;

      assign slot_cfg_we  = cfg_hit  && (csr_idx == IDX_W'(WORD));
      assign slot_addr_we = addr_hit && (csr_idx == IDX_W'(i));

      pcfg_region_slot #(
        .ADDR_W   (XLEN),
        .HAS_NEXT (i + 1 < NUM_REGIONS)
      ) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (slot_cfg_we),
        .cfg_wdata  (csr_wdata[LANE*CFG_W +: CFG_W]),
        .addr_we    (slot_addr_we),
        .addr_wdata (csr_wdata),
        .next_cfg   (cfg_arr[i+1]),
        .lockdown   (sec_q[SEC_LD]),
        .bypass     (sec_q[SEC_BYP]),
        .cfg_q      (cfg_arr[i]),
        .addr_q     (region_addr_o[i*XLEN +: XLEN])
      );

      assign region_cfg_o[i*CFG_W +: CFG_W] = cfg_arr[i];
    end
  endgenerate

  always_comb begin
    any_locked = 1'b0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      any_locked = any_locked | cfg_arr[i][BIT_L];
    end
  end

  pcfg_sec_reg u_sec (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (sec_we),
    .wdata      (csr_wdata[SEC_W-1:0]),
    .any_locked (any_locked),
    .sec_q      (sec_q)
  );

  pcfg_read_mux #(
    .NUM_REGIONS (NUM_REGIONS),
    .XLEN        (XLEN),
    .IDX_W       (IDX_W)
  ) u_rmux (
    .re        (csr_re),
    .sel       (csr_sel),
    .idx       (csr_idx),
    .cfg_flat  (region_cfg_o),
    .addr_flat (region_addr_o),
    .sec       (sec_q),
    .rdata     (csr_rdata)
  );

  assign sec_lockdown_o  = sec_q[SEC_LD];
  assign sec_whitelist_o = sec_q[SEC_WL];
  assign sec_bypass_o    = sec_q[SEC_BYP];

  // R10: out-of-range address index leaves every address untouched
  a_r10_oob_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_sel == 2'd1 && {1'b0, csr_idx} >= ADDR_LIMIT)
      |=> $stable(region_addr_o));

  // R10: out-of-range configuration index leaves every byte untouched
  a_r10_oob_cfg_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_sel == 2'd0 && {1'b0, csr_idx} >= CFG_LIMIT)
      |=> $stable(region_cfg_o));

  // R10: out-of-range reads return zero
  a_r10_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_re && (csr_sel == 2'd3 ||
                (csr_sel == 2'd1 && {1'b0, csr_idx} >= ADDR_LIMIT)))
      |-> (csr_rdata == '0));

  // R11: idle read port returns zero
  a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_re |-> (csr_rdata == '0));

endmodule

// File: tb/pcfg_regfile_bench.sv
`timescale 1ns/1ps
module pcfg_regfile_bench;

  logic         clk;
  logic         rst_n;
  logic         csr_we;
  logic         csr_re;
  logic [1:0]   csr_sel;
  logic [4:0]   csr_idx;
  logic [31:0]  csr_wdata;
  logic [31:0]  csr_rdata;
  logic [127:0] region_cfg_o;
  logic [511:0] region_addr_o;
  logic         sec_lockdown_o;
  logic         sec_whitelist_o;
  logic         sec_bypass_o;

  int n_chk;
  int n_fail;

  logic [7:0]  m_cfg  [16];
  logic [31:0] m_addr [16];
  logic [2:0]  m_sec;

  pcfg_regfile u_pcfg_regfile (
    .clk             (clk),
    .rst_n           (rst_n),
    .csr_we          (csr_we),
    .csr_re          (csr_re),
    .csr_sel         (csr_sel),
    .csr_idx         (csr_idx),
    .csr_wdata       (csr_wdata),
    .csr_rdata       (csr_rdata),
    .region_cfg_o    (region_cfg_o),
    .region_addr_o   (region_addr_o),
    .sec_lockdown_o  (sec_lockdown_o),
    .sec_whitelist_o (sec_whitelist_o),
    .sec_bypass_o    (sec_bypass_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string what, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic cfg_ok(input logic [7:0] old_v, input logic [7:0] new_v);
    if (m_sec[2]) return 1'b1;
    if (m_sec[0]) begin
      if (new_v[7]) return !new_v[2];
      return new_v[2:0] != 3'b110;
    end
    return !old_v[7];
  endfunction

  function automatic logic addr_ok(input int i);
    if (m_cfg[i][7]) return 1'b0;
    if (i < 15 && m_cfg[i+1][7] && m_cfg[i+1][4:3] == 2'b01) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [31:0] model_read(input logic [1:0] sel, input logic [4:0] idx);
    logic [31:0] r;
    r = '0;
    if (sel == 2'd0 && idx < 5'd4) begin
      for (int j = 0; j < 4; j++) r[8*j +: 8] = m_cfg[idx*4 + j];
    end else if (sel == 2'd1 && idx < 5'd16) begin
      r = m_addr[idx];
    end else if (sel == 2'd2) begin
      r[2:0] = m_sec;
    end
    return r;
  endfunction

  task automatic model_apply(input logic [1:0] sel, input logic [4:0] idx, input logic [31:0] d);
    logic        locked;
    logic [2:0]  ns;
    if (sel == 2'd0 && idx < 5'd4) begin
      for (int j = 0; j < 4; j++) begin
        if (cfg_ok(m_cfg[idx*4 + j], d[8*j +: 8])) m_cfg[idx*4 + j] = d[8*j +: 8];
      end
    end else if (sel == 2'd1 && idx < 5'd16) begin
      if (addr_ok(int'(idx))) m_addr[idx] = d;
    end else if (sel == 2'd2) begin
      locked = 1'b0;
      for (int i = 0; i < 16; i++) locked = locked | m_cfg[i][7];
      ns = d[2:0];
      if (!m_sec[2] && locked) ns[2] = 1'b0;
      ns[1:0] = ns[1:0] | m_sec[1:0];
      m_sec = ns;
    end
  endtask

  task automatic compare_all(input string tag);
    logic [127:0] ec;
    logic [511:0] ea;
    for (int i = 0; i < 16; i++) begin
      ec[8*i +: 8]  = m_cfg[i];
      ea[32*i +: 32] = m_addr[i];
    end
    check({tag, " region configs"}, 512'(region_cfg_o), 512'(ec));
    check({tag, " region addresses"}, region_addr_o, ea);
    check({tag, " security flags"},
          512'({sec_bypass_o, sec_whitelist_o, sec_lockdown_o}), 512'(m_sec));
  endtask

  task automatic do_reset();
    csr_we = 1'b0; csr_re = 1'b0; csr_sel = '0; csr_idx = '0; csr_wdata = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) begin m_cfg[i] = '0; m_addr[i] = '0; end
    m_sec = '0;
  endtask

  // write with the read strobe raised on the same register in the same cycle
  task automatic do_op(input logic [1:0] sel, input logic [4:0] idx,
                       input logic [31:0] d, input string tag);
    logic [31:0] exp_rd;
    @(negedge clk);
    exp_rd = model_read(sel, idx);
    csr_we = 1'b1; csr_re = 1'b1; csr_sel = sel; csr_idx = idx; csr_wdata = d;
    #1;
    check({tag, " R11 same-cycle read returns old value"}, 512'(csr_rdata), 512'(exp_rd));
    compare_all({tag, " R11 before edge"});
    model_apply(sel, idx, d);
    @(negedge clk);
    csr_we = 1'b0; csr_re = 1'b0;
    compare_all(tag);
  endtask

  task automatic rd_check(input logic [1:0] sel, input logic [4:0] idx, input string tag);
    @(negedge clk);
    csr_re = 1'b1; csr_sel = sel; csr_idx = idx;
    #1;
    check({tag, " readback"}, 512'(csr_rdata), 512'(model_read(sel, idx)));
    csr_re = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    n_chk = 0;
    n_fail = 0;

    // R11 reset state
    do_reset();
    @(negedge clk);
    check("R11 reset configs", 512'(region_cfg_o), '0);
    check("R11 reset addresses", region_addr_o, '0);
    check("R11 reset security", 512'({sec_bypass_o, sec_whitelist_o, sec_lockdown_o}), '0);
    check("R11 idle read is zero", 512'(csr_rdata), '0);

    // R1 / R2 field layout and lane packing
    for (int k = 0; k < 4; k++) begin
      do_op(2'd0, 5'(k), 32'h1B1A1918 + 32'(k) * 32'h04040404, "R2");
      for (int j = 0; j < 4; j++)
        check("R2 lane to region", 512'(region_cfg_o[8*(4*k+j) +: 8]),
              512'(8'h18 + 8'(4*k + j)));
      rd_check(2'd0, 5'(k), "R2");
    end
    do_op(2'd0, 5'd0, 32'h0000_001D, "R1");
    check("R1 read bit", 512'(region_cfg_o[0]), 512'(1'b1));
    check("R1 write bit", 512'(region_cfg_o[1]), 512'(1'b0));
    check("R1 execute bit", 512'(region_cfg_o[2]), 512'(1'b1));
    check("R1 match mode", 512'(region_cfg_o[4:3]), 512'(2'd3));
    for (int i = 0; i < 16; i++) begin
      do_op(2'd1, 5'(i), 32'hC000_0000 | 32'(i * 17), "R4");
      rd_check(2'd1, 5'(i), "R4");
    end

    // R3 / R4 / R5 sweep over every byte for region 5
    for (int v = 0; v < 256; v++) begin
      do_reset();
      do_op(2'd1, 5'd5, 32'h1000_0000 | 32'(v), "R4");
      do_op(2'd1, 5'd4, 32'h2000_0000 | 32'(v), "R5");
      do_op(2'd0, 5'd1, {16'h0000, 8'(v), 8'h0F}, "R3");
      do_op(2'd0, 5'd1, 32'h0000_0000, "R3");
      do_op(2'd1, 5'd5, 32'hA5A5_0000 | 32'(v), "R4");
      do_op(2'd1, 5'd4, 32'h5A5A_0000 | 32'(v), "R5");
    end
    // R5 top region has no neighbour
    do_reset();
    do_op(2'd0, 5'd3, 32'h0800_0000, "R5");
    do_op(2'd1, 5'd15, 32'h0000_BEEF, "R5");
    check("R5 top region address", 512'(region_addr_o[32*15 +: 32]), 512'(32'h0000_BEEF));

    // R6 bypass then bypass plus lockdown
    do_reset();
    do_op(2'd2, 5'd0, 32'h4, "R6");
    check("R6 bypass raised", 512'(sec_bypass_o), 512'(1'b1));
    for (int v = 0; v < 256; v++) begin
      if (v == 128) do_op(2'd2, 5'd0, 32'h5, "R6");
      do_op(2'd0, 5'(v % 4), {8'(v), 8'(v) ^ 8'hFF, 8'(v) ^ 8'h80, 8'(v)}, "R6");
    end

    // R7 lockdown rule over every byte, old lock both ways
    for (int v = 0; v < 256; v++) begin
      do_reset();
      do_op(2'd0, 5'd0, (v % 2 == 1) ? 32'h0000_0081 : 32'h0000_0001, "R7");
      do_op(2'd2, 5'd0, 32'h1, "R7");
      do_op(2'd0, 5'd0, {8'h86, 8'h06, 8'h82, 8'(v)}, "R7");
    end

    // R8 stickiness
    do_reset();
    do_op(2'd2, 5'd9, 32'h3, "R8");
    do_op(2'd2, 5'd0, 32'h0, "R8");
    check("R8 lockdown stays set", 512'(sec_lockdown_o), 512'(1'b1));
    check("R8 whitelist stays set", 512'(sec_whitelist_o), 512'(1'b1));
    rd_check(2'd2, 5'd0, "R8");

    // R9 bypass guard
    do_reset();
    do_op(2'd0, 5'd2, 32'h8000_0000, "R9");
    do_op(2'd2, 5'd0, 32'h4, "R9");
    check("R9 bypass blocked by lock", 512'(sec_bypass_o), 512'(1'b0));
    do_reset();
    do_op(2'd2, 5'd0, 32'h4, "R9");
    do_op(2'd0, 5'd2, 32'h8000_0000, "R9");
    do_op(2'd2, 5'd0, 32'h0, "R9");
    check("R9 bypass clears", 512'(sec_bypass_o), 512'(1'b0));
    do_op(2'd2, 5'd0, 32'h4, "R9");
    check("R9 bypass cannot return", 512'(sec_bypass_o), 512'(1'b0));

    // R10 out-of-range access
    do_reset();
    for (int i = 0; i < 16; i++) do_op(2'd1, 5'(i), 32'h7700_0000 | 32'(i), "R10");
    for (int i = 4; i < 32; i++) begin
      do_op(2'd0, 5'(i), 32'hFFFF_FFFF, "R10");
      rd_check(2'd0, 5'(i), "R10");
    end
    for (int i = 16; i < 32; i++) begin
      do_op(2'd1, 5'(i), 32'hFFFF_FFFF, "R10");
      rd_check(2'd1, 5'(i), "R10");
    end
    do_op(2'd3, 5'd0, 32'hFFFF_FFFF, "R10");
    rd_check(2'd3, 5'd1, "R10");

    finish_run();
  end

endmodule